// File: doc/BRIEF.md
# Early-Terminating Iterative Prefix-Carry Adder

This block adds two wide unsigned operands over several clock cycles. The operands are cut into `N` lanes of `D` bits. Each lane first adds its own two digits and reduces the result to a propagate/generate pair. Then one level of a Kogge-Stone style prefix scan runs per clock. At level `i`, every lane merges its pair with the pair held by the lane `2^i` positions further down.

The scan does not always run all `log2 N` levels. Once enough levels have run, a single OR over the propagate bits of lanes 1 and up is tested after every level. The scan stops as soon as that OR is zero. Either way, one final cycle moves each lane's generate bit up one lane as its incoming carry and forms the sum. Most operand pairs therefore finish well before the worst case. A control input can force the full number of levels.

Operands enter through a valid/ready handshake. `in_ready` is high only while the adder is idle, so a source holding `in_valid` simply waits; an offer made while busy is not taken. The result side has no back-pressure: `out_valid` is a one-cycle pulse, and the result outputs keep their value until the next result. Subtraction is done by inverting `op_b` and forcing the carry-in to one.

Top module: `wide_prefix_adder`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid`, `sum`, `carry_out` and `step_count` are all 0.
- R2: An operand set is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle on and returns to 1 in the cycle after `out_valid`. An `in_valid` offered while `in_ready` is 0 is ignored and does not change the pending result.
- R3: With `sub_en`=0, `{carry_out, sum}` equals `op_a + op_b + carry_in` computed at full width plus one bit.
- R4: With `sub_en`=1, `sum` equals `op_a - op_b` modulo 2^(N*D), and `carry_out` is 1 exactly when `op_a >= op_b`. `carry_in` has no effect.
- R5: With `full_steps`=0, `step_count` equals max(floor(log2(log2 N)), k). Here k is 0 when m is 0 and floor(log2 m)+1 otherwise. m is the longest run of consecutive lanes among lanes 1..N-1 whose local digit sum has all D low bits set. The local digit sum of lane j is `op_a` bits [jD+D-1:jD] plus the matching bits of the effective B, which is `op_b` inverted when `sub_en`=1. Lane 0 never counts.
- R6: With `full_steps`=1, `step_count` equals log2 N and the result obeys R3/R4.
- R7: `out_valid` is high for exactly one cycle per result. `sum`, `carry_out` and `step_count` do not change while `out_valid` is 0.
- R8: `out_valid` is seen `step_count`+1 clock edges after the edge that took the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Adder idle, offer will be taken |
| op_a | input | N*D | First operand |
| op_b | input | N*D | Second operand (subtrahend when sub_en=1) |
| carry_in | input | 1 | Carry into lane 0 for addition |
| sub_en | input | 1 | 1: compute op_a - op_b |
| full_steps | input | 1 | 1: disable early stop, run all log2 N levels |
| out_valid | output | 1 | One-cycle pulse, result valid |
| sum | output | N*D | Result, held until the next result |
| carry_out | output | 1 | Carry out of the top lane (no-borrow flag when subtracting) |
| step_count | output | $clog2(log2 N + 1) | Scan levels actually run |

## Verification
The checks take for granted that operands, `carry_in`, `sub_en` and `full_steps` are known (not X) on the edge that takes them. Their values at other times are never sampled. The checks also assume every result pulse follows an accepted operand set, which always holds after reset. The bench changes inputs only on falling edges. It drives data only when it wants a transfer, except in the scenario that deliberately offers operands while the adder is busy. Operand patterns are built to place propagate runs of chosen lengths in chosen lanes, so each termination step from the earliest check up to the full depth is reached.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } wpa_state_e;

  // Position of the highest set bit; 0 for inputs 0 and 1.
  function automatic int unsigned floor_log2(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 1; i < 32; i++) begin
      if ((v >> i) != 0) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/wpa_lane_seed.sv
module wpa_lane_seed #(
  parameter int unsigned D        = 2,
  parameter bit          LSB_LANE = 1'b0
) (
  input  logic [D-1:0] a_dig,
  input  logic [D-1:0] b_dig,
  input  logic         cin,
  output logic [D-1:0] loc_sum,
  output logic         prop,
  output logic         gen
);

  logic [D:0] wide;

  always_comb begin
    wide    = {1'b0, a_dig} + {1'b0, b_dig} + {{D{1'b0}}, cin};
    loc_sum = wide[D-1:0];
    gen     = wide[D];
    // The bottom lane has nothing below it, so its generate is already final.
    prop    = LSB_LANE ? 1'b0 : (&wide[D-1:0]);
  end

endmodule

// File: rtl/wpa_scan_level.sv
module wpa_scan_level #(
  parameter int unsigned N  = 16,
  parameter int unsigned SW = 3
) (
  input  logic [N-1:0]  p_in,
  input  logic [N-1:0]  g_in,
  input  logic [SW-1:0] lvl,
  output logic [N-1:0]  p_out,
  output logic [N-1:0]  g_out
);

  localparam int unsigned LOGN = $clog2(N);

  // Neighbour pair at every possible distance, with a flag saying whether it exists.
  logic [N-1:0][LOGN-1:0] nb_p;
  logic [N-1:0][LOGN-1:0] nb_g;
  logic [N-1:0][LOGN-1:0] nb_ok;

  for (genvar j = 0; j < N; j++) begin : g_lane
    for (genvar k = 0; k < LOGN; k++) begin : g_dist
      if (j >= (1 << k)) begin : g_has
        assign nb_p[j][k]  = p_in[j - (1 << k)];
        assign nb_g[j][k]  = g_in[j - (1 << k)];
        assign nb_ok[j][k] = 1'b1;
      end else begin : g_none
        assign nb_p[j][k]  = 1'b0;
        assign nb_g[j][k]  = 1'b0;
        assign nb_ok[j][k] = 1'b0;
      end
    end

    logic sel_ok, sel_p, sel_g;

    always_comb begin
      sel_ok = 1'b0;
      sel_p  = 1'b0;
      sel_g  = 1'b0;
      for (int k = 0; k < LOGN; k++) begin
        if (lvl == SW'(k)) begin
          sel_ok = nb_ok[j][k];
          sel_p  = nb_p[j][k];
          sel_g  = nb_g[j][k];
        end
      end
      if (sel_ok) begin
        p_out[j] = p_in[j] & sel_p;
        g_out[j] = g_in[j] | (p_in[j] & sel_g);
      end else begin
        p_out[j] = p_in[j];
        g_out[j] = g_in[j];
      end
    end
  end

endmodule

// File: rtl/wpa_lane_finish.sv
module wpa_lane_finish #(
  parameter int unsigned N = 16,
  parameter int unsigned D = 2
) (
  input  logic [N*D-1:0] loc_sum,
  input  logic [N-2:0]   carry_src,
  output logic [N*D-1:0] sum
);

  for (genvar j = 0; j < N; j++) begin : g_lane
    if (j == 0) begin : g_bottom
      assign sum[D-1:0] = loc_sum[D-1:0];
    end else begin : g_upper
      assign sum[j*D +: D] = loc_sum[j*D +: D] + D'(carry_src[j-1]);
    end
  end

endmodule

// File: rtl/wide_prefix_adder.sv
module wide_prefix_adder
  import wpa_pkg::*;
#(
  parameter  int unsigned N    = 16,
  parameter  int unsigned D    = 2,
  localparam int unsigned W    = N * D,
  localparam int unsigned LOGN = $clog2(N),
  localparam int unsigned SW   = $clog2(LOGN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          carry_in,
  input  logic          sub_en,
  input  logic          full_steps,
  output logic          out_valid,
  output logic [W-1:0]  sum,
  output logic          carry_out,
  output logic [SW-1:0] step_count
);

  localparam int unsigned CHK = floor_log2(LOGN);

  wpa_state_e    state_q;
  logic [SW-1:0] lvl_q;
  logic [N-1:0]  p_q, g_q;
  logic [W-1:0]  loc_q;
  logic          full_q;
  logic [W-1:0]  sum_q;
  logic          cout_q;
  logic [SW-1:0] steps_q;

  logic [W-1:0]  b_eff;
  logic          cin_eff;
  logic [W-1:0]  seed_loc;
  logic [N-1:0]  seed_p, seed_g;
  logic [N-1:0]  p_nxt, g_nxt;
  logic [W-1:0]  fin_sum;
  logic          prop_any, at_top, may_check, stop_now;

  assign b_eff   = sub_en ? ~op_b : op_b;
  assign cin_eff = sub_en | carry_in;

  for (genvar j = 0; j < N; j++) begin : g_seed
    wpa_lane_seed #(
      .D        (D),
      .LSB_LANE (j == 0)
    ) seed_i (
      .a_dig   (op_a[j*D +: D]),
      .b_dig   (b_eff[j*D +: D]),
      .cin     ((j == 0) ? cin_eff : 1'b0),
      .loc_sum (seed_loc[j*D +: D]),
      .prop    (seed_p[j]),
      .gen     (seed_g[j])
    );
  end

  wpa_scan_level #(
    .N  (N),
    .SW (SW)
  ) scan_i (
    .p_in  (p_q),
    .g_in  (g_q),
    .lvl   (lvl_q),
    .p_out (p_nxt),
    .g_out (g_nxt)
  );

  wpa_lane_finish #(
    .N (N),
    .D (D)
  ) finish_i (
    .loc_sum   (loc_q),
    .carry_src (g_q[N-2:0]),
    .sum       (fin_sum)
  );

  assign prop_any  = |p_q[N-1:1];
  assign at_top    = (lvl_q == SW'(LOGN));
  assign may_check = !full_q && (lvl_q >= SW'(CHK));
  assign stop_now  = at_top || (may_check && !prop_any);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      p_q     <= '0;
      g_q     <= '0;
      loc_q   <= '0;
      full_q  <= 1'b0;
      sum_q   <= '0;
      cout_q  <= 1'b0;
      steps_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            loc_q   <= seed_loc;
            p_q     <= seed_p;
            g_q     <= seed_g;
            full_q  <= full_steps;
            lvl_q   <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (stop_now) begin
            sum_q   <= fin_sum;
            cout_q  <= g_q[N-1];
            steps_q <= lvl_q;
            state_q <= ST_FIN;
          end else begin
            p_q   <= p_nxt;
            g_q   <= g_nxt;
            lvl_q <= lvl_q + SW'(1);
          end
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign in_ready   = (state_q == ST_IDLE);
  assign out_valid  = (state_q == ST_FIN);
  assign sum        = sum_q;
  assign carry_out  = cout_q;
  assign step_count = steps_q;

endmodule

// File: rtl/wpa_checker.sv
module wpa_checker
  import wpa_pkg::*;
#(
  parameter  int unsigned N    = 16,
  parameter  int unsigned D    = 2,
  localparam int unsigned W    = N * D,
  localparam int unsigned LOGN = $clog2(N),
  localparam int unsigned SW   = $clog2(LOGN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic          carry_in,
  input logic          sub_en,
  input logic          full_steps,
  input logic          out_valid,
  input logic [W-1:0]  sum,
  input logic          carry_out,
  input logic [SW-1:0] step_count,
  input logic [N-1:0]  p_q,
  input logic [N-1:0]  g_q
);

  localparam int unsigned CHK = floor_log2(LOGN);

  logic [W:0]   exp_q;
  logic         full_cap;
  logic [7:0]   lat_q;
  logic         take;

  assign take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q    <= '0;
      full_cap <= 1'b0;
      lat_q    <= '0;
    end else begin
      if (take) begin
        exp_q    <= {1'b0, op_a} + {1'b0, (sub_en ? ~op_b : op_b)} + (W+1)'(sub_en | carry_in);
        full_cap <= full_steps;
        lat_q    <= '0;
      end else if (!in_ready && lat_q != 8'hFF) begin
        lat_q <= lat_q + 8'd1;
      end
    end
  end

  p_take_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  p_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready);

  p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({carry_out, sum} == exp_q));

  p_step_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (step_count <= SW'(LOGN)) && (step_count >= SW'(CHK)));

  // R5: the scan never holds a lane that both propagates and generates.
  p_no_pg_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (p_q & g_q) == '0);

  p_full_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && full_cap) |-> (step_count == SW'(LOGN)));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(sum) && $stable(carry_out) && $stable(step_count)));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_q == 8'(step_count) + 8'd1));

endmodule

bind wide_prefix_adder wpa_checker #(.N(N), .D(D)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .op_a       (op_a),
  .op_b       (op_b),
  .carry_in   (carry_in),
  .sub_en     (sub_en),
  .full_steps (full_steps),
  .out_valid  (out_valid),
  .sum        (sum),
  .carry_out  (carry_out),
  .step_count (step_count),
  .p_q        (p_q),
  .g_q        (g_q)
);

// File: tb/wide_prefix_adder_tb_top.sv
module wide_prefix_adder_tb_top;

  localparam int unsigned N          = 16;
  localparam int unsigned D          = 2;
  localparam int unsigned W          = N * D;
  localparam int unsigned LOGN       = 4;
  localparam int unsigned SW         = 3;
  localparam int unsigned CHK        = 2;
  localparam time         CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          carry_in = 1'b0;
  logic          sub_en = 1'b0;
  logic          full_steps = 1'b0;
  logic          out_valid;
  logic [W-1:0]  sum;
  logic          carry_out;
  logic [SW-1:0] step_count;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] rng = 32'h1F2E_3D4C;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wide_prefix_adder #(.N(N), .D(D)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .op_a       (op_a),
    .op_b       (op_b),
    .carry_in   (carry_in),
    .sub_en     (sub_en),
    .full_steps (full_steps),
    .out_valid  (out_valid),
    .sum        (sum),
    .carry_out  (carry_out),
    .step_count (step_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int unsigned flog2(input int unsigned v);
    int unsigned r = 0;
    for (int i = 1; i < 32; i++) if ((v >> i) != 0) r = i;
    return r;
  endfunction

  function automatic logic [W:0] ref_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic cin, input logic sub);
    logic [W-1:0] bb;
    bb = sub ? ~b : b;
    return {1'b0, a} + {1'b0, bb} + (W+1)'(sub | cin);
  endfunction

  function automatic int unsigned ref_steps(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic sub, input logic full);
    logic [W-1:0] bb;
    logic [D:0]   ls;
    int unsigned  run, m, need;
    bb = sub ? ~b : b;
    run = 0;
    m = 0;
    for (int j = 1; j < N; j++) begin
      ls = {1'b0, a[j*D +: D]} + {1'b0, bb[j*D +: D]};
      if (&ls[D-1:0]) run++;
      else run = 0;
      if (run > m) m = run;
    end
    need = (m == 0) ? 0 : flog2(m) + 1;
    if (full) return LOGN;
    return (need > CHK) ? need : CHK;
  endfunction

  // Offer one operand set, wait for the pulse, count edges from acceptance.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic cin,
                        input logic sub, input logic full, output int lat);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    op_a = a; op_b = b; carry_in = cin; sub_en = sub; full_steps = full;
    in_valid = 1'b1;
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      in_valid = 1'b0;
      if (out_valid) break;
      lat++;
      if (lat > 200) break;
    end
  endtask

  task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic cin,
                       input logic sub, input logic full);
    int lat;
    logic [W:0] er;
    int unsigned es;
    er = ref_result(a, b, cin, sub);
    es = ref_steps(a, b, sub, full);
    run_op(a, b, cin, sub, full, lat);
    check(sum == er[W-1:0], sub ? "R4" : "R3", "sum", 64'(sum), 64'(er[W-1:0]));
    check(carry_out == er[W], sub ? "R4" : "R3", "carry_out", 64'(carry_out), 64'(er[W]));
    check(step_count == SW'(es), full ? "R6" : "R5", "step_count", 64'(step_count), 64'(es));
    check(lat == int'(es) + 1, "R8", "latency", 64'(lat), 64'(es + 1));
  endtask

  function automatic logic [W-1:0] lanes_set(input int lo, input int hi);
    logic [W-1:0] v = '0;
    for (int j = lo; j <= hi; j++) v[j*D +: D] = '1;
    return v;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R1", "out_valid", 64'(out_valid), 64'd0);
    check(sum == '0, "R1", "sum", 64'(sum), 64'd0);
    check(carry_out == 1'b0, "R1", "carry_out", 64'(carry_out), 64'd0);
    check(step_count == '0, "R1", "step_count", 64'(step_count), 64'd0);
  endtask

  task automatic t_add_basic;
    do_op(32'd5, 32'd7, 1'b1, 1'b0, 1'b0);
    do_op(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0);
    do_op(32'h1234_5678, 32'h8765_4321, 1'b0, 1'b0, 1'b0);
    do_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_propagate_extremes;
    do_op('0, '0, 1'b0, 1'b0, 1'b0);            // R5: no run, earliest check
    do_op('1, '0, 1'b0, 1'b0, 1'b0);            // R5: full-length run
    do_op('1, '0, 1'b1, 1'b0, 1'b0);            // R3: ripple across every lane
  endtask

  task automatic t_runs;
    do_op(lanes_set(1, 1), '0, 1'b1, 1'b0, 1'b0);   // R5 m=1
    do_op(lanes_set(5, 7), '0, 1'b0, 1'b0, 1'b0);   // R5 m=3
    do_op(lanes_set(1, 4), '0, 1'b1, 1'b0, 1'b0);   // R5 m=4
    do_op(lanes_set(3, 10), 32'h0000_0003, 1'b1, 1'b0, 1'b0); // R5 m=8
    do_op(lanes_set(8, 15), '0, 1'b0, 1'b0, 1'b0);  // R5 run at the top
  endtask

  task automatic t_subtract;
    do_op(32'd100, 32'd1, 1'b0, 1'b1, 1'b0);
    do_op(32'd1, 32'd2, 1'b0, 1'b1, 1'b0);          // R4 borrow
    do_op(32'd77, 32'd77, 1'b0, 1'b1, 1'b0);
    do_op(32'd77, 32'd77, 1'b1, 1'b1, 1'b0);        // R4 carry_in ignored
  endtask

  task automatic t_full_depth;
    do_op('0, '0, 1'b0, 1'b0, 1'b1);                // R6
    do_op(32'd3, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1);  // R6 small negative
  endtask

  task automatic t_busy_offer;
    logic [W:0] er;
    er = ref_result(32'h0000_00F0, 32'h0000_000F, 1'b0, 1'b0);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    op_a = 32'h0000_00F0; op_b = 32'h0000_000F; carry_in = 1'b0; sub_en = 1'b0;
    full_steps = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_a = 32'hDEAD_BEEF; op_b = 32'h1111_1111; carry_in = 1'b1;
    check(in_ready == 1'b0, "R2", "in_ready while busy", 64'(in_ready), 64'd0);
    @(negedge clk);
    check(in_ready == 1'b0, "R2", "in_ready while busy", 64'(in_ready), 64'd0);
    in_valid = 1'b0;
    for (int i = 0; i < 50 && !out_valid; i++) @(negedge clk);
    check(sum == er[W-1:0], "R2", "sum after busy offer", 64'(sum), 64'(er[W-1:0]));
    @(negedge clk);
    check(in_ready == 1'b1, "R2", "in_ready after pulse", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R7", "pulse width", 64'(out_valid), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(sum == er[W-1:0] && !out_valid, "R7", "held sum", 64'(sum), 64'(er[W-1:0]));
    end
  endtask

  task automatic t_mixed;
    logic [W-1:0] a, b;
    for (int i = 0; i < 24; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      a = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      b = (i % 3 == 0) ? ~a : rng;
      do_op(a, b, rng[3], rng[7], (i % 5 == 0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add_basic();
    t_propagate_extremes();
    t_runs();
    t_subtract();
    t_full_depth();
    t_busy_offer();
    t_mixed();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule